// File: doc/BRIEF.md
# Ternary Hypervector Operation Unit

This block applies one arithmetic operation per command to a pair of balanced-ternary hypervectors. Each vector is a packed bus with a 2-bit code per trit, and every trit is one lane. A command carries an opcode and a rotation amount. The unit can do five things: an elementwise trit product (bind), a two-input sign-of-sum vote (bundle), a cyclic lane rotation, a rectifier that clears negative trits, and a similarity dot product.

The four vector operations are computed across all lanes in parallel. Their result is registered, so it appears on the vector output one clock after the command, together with a one-cycle valid pulse. The dot product sums the lane-wise trit products through a three-stage pipelined adder tree. It accepts a new command every cycle and returns a signed scalar, with its own valid flag, three cycles after the command.

The unit is meant to sit beside a vector memory and a sequencer, which are outside this block. Those feed operand pairs in and collect results.

Top module: `tvec_op_unit`

## Requirements
- R1: Trit codes are 2'b00 = 0, 2'b01 = +1, 2'b10 = -1. An input lane carrying 2'b11 is treated exactly as 0 by every operation.
- R2: No lane of `vec_out` ever carries the code 2'b11.
- R3: Opcode 0 (bind) registers, for every lane, the product of the two input trits. The result is on `vec_out` one clock after the command.
- R4: Opcode 1 (bundle) registers, for every lane, the sign of a+b. Equal trits pass through, opposite trits give 0, and 0 with x gives x.
- R5: Opcode 2 (rotate) moves input lane i of `vec_a` to output lane (i + `cmd_shift`) mod LANES. A shift of 0 returns the cleaned vector unchanged.
- R6: Opcode 3 (rectify) maps each -1 lane of `vec_a` to 0 and keeps the 0 and +1 lanes.
- R7: Opcode 4 (dot) produces the signed sum of the lane products on `dot_out`, within -LANES..+LANES. `dot_valid` is high exactly three clocks after each dot command, and back-to-back dot commands give back-to-back results.
- R8: `vec_valid` pulses for one cycle one clock after each accepted vector command (opcodes 0-3). At all other times `vec_out` holds its value, including across dot commands.
- R9: A command with `cmd_valid` low, or one with opcode 5, 6 or 7, raises no valid flag and leaves both outputs unchanged.
- R10: While `rst_n` is low, `vec_out` is all-zero trits, `dot_out` is 0, and both valid flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode: 0 bind, 1 bundle, 2 rotate, 3 rectify, 4 dot |
| cmd_shift | input | $clog2(LANES) | Rotation amount in lanes |
| vec_a | input | 2*LANES | First operand, 2 bits per trit |
| vec_b | input | 2*LANES | Second operand, 2 bits per trit |
| vec_out | output | 2*LANES | Registered vector result |
| vec_valid | output | 1 | One-cycle pulse for a new vector result |
| dot_out | output | $clog2(LANES)+2 | Signed dot-product result |
| dot_valid | output | 1 | One-cycle pulse for a new dot result |

## Verification
The hardest case to reach is a steady stream of dot commands, each with different operands, arriving on consecutive cycles. In that case all three adder-tree stages hold data from three different commands at once, so any stage that mixes its neighbours shows up only there. The bench issues a run of back-to-back dot commands built from a pseudo-random generator and matches each result, in order, three cycles after its command. It also uses a lane pattern that places all sixteen input code pairs, the illegal code included, side by side in one vector. This lets each operation's whole truth table, and every rotation amount, be checked in one sweep.

// File: rtl/tvec_pkg.sv
package tvec_pkg;

   typedef enum logic [2:0] {
      OP_BIND   = 3'd0,
      OP_BUNDLE = 3'd1,
      OP_ROTATE = 3'd2,
      OP_RELU   = 3'd3,
      OP_DOT    = 3'd4
   } op_e;

   localparam logic [1:0] TRIT_ZERO = 2'b00;
   localparam logic [1:0] TRIT_POS  = 2'b01;
   localparam logic [1:0] TRIT_NEG  = 2'b10;

   // vector opcodes are the four lowest codes
   function automatic logic is_vec_op(input logic [2:0] op);
      return (op == OP_BIND) || (op == OP_BUNDLE) ||
             (op == OP_ROTATE) || (op == OP_RELU);
   endfunction

   // pack a sign pair into a trit code; never yields 2'b11 when pos/neg exclusive
   function automatic logic [1:0] trit_pack(input logic pos, input logic neg);
      return {neg & ~pos, pos & ~neg};
   endfunction

endpackage

// File: rtl/tvec_lane.sv
module tvec_lane
   import tvec_pkg::*;
(
   input  logic [1:0] a_code,
   input  logic [1:0] b_code,
   output logic [1:0] clean_a,
   output logic [1:0] bind_code,
   output logic [1:0] bundle_code,
   output logic [1:0] relu_code,
   output logic       prod_pos,
   output logic       prod_neg
);

   logic a_pos, a_neg, b_pos, b_neg;

   // the illegal code 2'b11 decodes as neither sign, i.e. zero
   assign a_pos = (a_code == TRIT_POS);
   assign a_neg = (a_code == TRIT_NEG);
   assign b_pos = (b_code == TRIT_POS);
   assign b_neg = (b_code == TRIT_NEG);

   assign clean_a  = trit_pack(a_pos, a_neg);

   // trit product
   assign prod_pos = (a_pos & b_pos) | (a_neg & b_neg);
   assign prod_neg = (a_pos & b_neg) | (a_neg & b_pos);
   assign bind_code = trit_pack(prod_pos, prod_neg);

   // sign of a+b
   assign bundle_code = trit_pack((a_pos & ~b_neg) | (b_pos & ~a_neg),
                                  (a_neg & ~b_pos) | (b_neg & ~a_pos));

   // negative lanes cleared
   assign relu_code = trit_pack(a_pos, 1'b0);

endmodule

// File: rtl/tvec_rotator.sv
module tvec_rotator #(
   parameter  int LANES   = 256,
   localparam int SHIFT_W = $clog2(LANES),
   localparam int BUS_W   = 2 * LANES
) (
   input  logic [BUS_W-1:0]   vec_in,
   input  logic [SHIFT_W-1:0] shift,
   output logic [BUS_W-1:0]   vec_rot
);

   logic [BUS_W-1:0] stage [SHIFT_W+1];

   assign stage[0] = vec_in;

   // log-depth barrel: stage k moves every lane up by 2**k when its bit is set
   for (genvar k = 0; k < SHIFT_W; k++) begin : g_stage
      localparam int BITS = 2 * (1 << k);
      assign stage[k+1] = shift[k] ?
         {stage[k][BUS_W-1-BITS:0], stage[k][BUS_W-1:BUS_W-BITS]} : stage[k];
   end

   assign vec_rot = stage[SHIFT_W];

endmodule

// File: rtl/tvec_dot_tree.sv
module tvec_dot_tree #(
   parameter  int LANES = 256,
   parameter  int GRP1  = 16,
   parameter  int GRP2  = 4,
   localparam int N1    = LANES / GRP1,
   localparam int N2    = N1 / GRP2,
   localparam int W1    = $clog2(GRP1) + 2,
   localparam int W2    = $clog2(GRP1 * GRP2) + 2,
   localparam int SUM_W = $clog2(LANES) + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [LANES-1:0]        prod_pos,
   input  logic [LANES-1:0]        prod_neg,
   output logic signed [SUM_W-1:0] out_sum,
   output logic                    out_valid
);

   logic signed [W1-1:0] s1_q [N1];
   logic signed [W2-1:0] s2_q [N2];
   logic signed [SUM_W-1:0] s3_d;
   logic [2:0] vpipe;

   // stage 1: count +1 minus -1 lanes per group
   for (genvar g = 0; g < N1; g++) begin : g_s1
      logic signed [W1-1:0] acc;
      always_comb begin
         acc = '0;
         for (int j = 0; j < GRP1; j++) begin
            acc = acc + W1'(prod_pos[g*GRP1+j]) - W1'(prod_neg[g*GRP1+j]);
         end
      end
      always_ff @(posedge clk) begin
         s1_q[g] <= acc;
      end
   end

   // stage 2: fold groups of partial sums
   for (genvar h = 0; h < N2; h++) begin : g_s2
      logic signed [W2-1:0] acc;
      always_comb begin
         acc = '0;
         for (int j = 0; j < GRP2; j++) begin
            acc = acc + W2'(s1_q[h*GRP2+j]);
         end
      end
      always_ff @(posedge clk) begin
         s2_q[h] <= acc;
      end
   end

   // stage 3: final reduction
   always_comb begin
      s3_d = '0;
      for (int k = 0; k < N2; k++) begin
         s3_d = s3_d + SUM_W'(s2_q[k]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpipe   <= '0;
         out_sum <= '0;
      end else begin
         vpipe <= {vpipe[1:0], in_valid};
         if (vpipe[1]) begin
            out_sum <= s3_d;
         end
      end
   end

   assign out_valid = vpipe[2];

endmodule

// File: rtl/tvec_op_unit.sv
module tvec_op_unit
   import tvec_pkg::*;
#(
   parameter  int LANES   = 256,
   parameter  int GRP1    = 16,
   parameter  int GRP2    = 4,
   localparam int SHIFT_W = $clog2(LANES),
   localparam int SUM_W   = $clog2(LANES) + 2,
   localparam int BUS_W   = 2 * LANES
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   input  logic [2:0]              cmd_op,
   input  logic [SHIFT_W-1:0]      cmd_shift,
   input  logic [BUS_W-1:0]        vec_a,
   input  logic [BUS_W-1:0]        vec_b,
   output logic [BUS_W-1:0]        vec_out,
   output logic                    vec_valid,
   output logic signed [SUM_W-1:0] dot_out,
   output logic                    dot_valid
);

   // elaboration-time parameter checks
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (GRP1 < 1 || (LANES % GRP1) != 0) begin : g_bad_grp1
      $error("GRP1 must divide LANES");
   end
   if (GRP2 < 1 || ((LANES / GRP1) % GRP2) != 0) begin : g_bad_grp2
      $error("GRP2 must divide LANES/GRP1");
   end

   logic [BUS_W-1:0] a_clean, bind_bus, bundle_bus, relu_bus, rot_bus, next_vec;
   logic [LANES-1:0] prod_pos, prod_neg;
   logic             accept_vec, accept_dot;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      tvec_lane u_lane (
         .a_code      (vec_a[2*i +: 2]),
         .b_code      (vec_b[2*i +: 2]),
         .clean_a     (a_clean[2*i +: 2]),
         .bind_code   (bind_bus[2*i +: 2]),
         .bundle_code (bundle_bus[2*i +: 2]),
         .relu_code   (relu_bus[2*i +: 2]),
         .prod_pos    (prod_pos[i]),
         .prod_neg    (prod_neg[i])
      );
   end

   tvec_rotator #(.LANES(LANES)) u_rot (
      .vec_in  (a_clean),
      .shift   (cmd_shift),
      .vec_rot (rot_bus)
   );

   assign accept_vec = cmd_valid && is_vec_op(cmd_op);
   assign accept_dot = cmd_valid && (cmd_op == OP_DOT);

   always_comb begin
      case (cmd_op)
         OP_BIND:   next_vec = bind_bus;
         OP_BUNDLE: next_vec = bundle_bus;
         OP_ROTATE: next_vec = rot_bus;
         OP_RELU:   next_vec = relu_bus;
         default:   next_vec = vec_out;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= accept_vec;
         if (accept_vec) begin
            vec_out <= next_vec;
         end
      end
   end

   tvec_dot_tree #(.LANES(LANES), .GRP1(GRP1), .GRP2(GRP2)) u_dot (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (accept_dot),
      .prod_pos  (prod_pos),
      .prod_neg  (prod_neg),
      .out_sum   (dot_out),
      .out_valid (dot_valid)
   );

endmodule

// File: rtl/tvec_op_unit_chk.sv
module tvec_op_unit_chk
   import tvec_pkg::*;
#(
   parameter  int LANES   = 256,
   localparam int SUM_W   = $clog2(LANES) + 2,
   localparam int BUS_W   = 2 * LANES
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cmd_valid,
   input logic [2:0]              cmd_op,
   input logic [BUS_W-1:0]        vec_out,
   input logic                    vec_valid,
   input logic signed [SUM_W-1:0] dot_out,
   input logic                    dot_valid
);

   logic       armed;
   logic [2:0] dot_track;
   logic       any_illegal, any_neg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         dot_track <= '0;
      end else begin
         armed     <= 1'b1;
         dot_track <= {dot_track[1:0], cmd_valid && (cmd_op == OP_DOT)};
      end
   end

   always_comb begin
      any_illegal = 1'b0;
      any_neg     = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         any_illegal = any_illegal | (vec_out[2*i +: 2] == 2'b11);
         any_neg     = any_neg     | (vec_out[2*i +: 2] == TRIT_NEG);
      end
   end

   p_legal_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !any_illegal);

   p_rectify_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed && vec_valid && $past(cmd_valid && cmd_op == OP_RELU) |-> !any_neg);

   p_dot_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dot_valid == dot_track[2]);

   p_dot_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dot_valid |-> (dot_out >= -LANES) && (dot_out <= LANES));

   p_vec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> vec_valid == $past(cmd_valid && is_vec_op(cmd_op)));

   p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !vec_valid |-> $stable(vec_out));

   p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(!cmd_valid || cmd_op > 3'd4) |-> !vec_valid);

endmodule

bind tvec_op_unit tvec_op_unit_chk #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .vec_out   (vec_out),
   .vec_valid (vec_valid),
   .dot_out   (dot_out),
   .dot_valid (dot_valid)
);

// File: tb/tvec_op_unit_bench.sv
module tvec_op_unit_bench;

   localparam int N     = 16;
   localparam int SW    = 4;
   localparam int SUMW  = 6;
   localparam int BW    = 2 * N;
   localparam int NSTR  = 24;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid = 1'b0;
   logic [2:0]      cmd_op = '0;
   logic [SW-1:0]   cmd_shift = '0;
   logic [BW-1:0]   vec_a = '0;
   logic [BW-1:0]   vec_b = '0;
   logic [BW-1:0]   vec_out;
   logic            vec_valid;
   logic signed [SUMW-1:0] dot_out;
   logic            dot_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #4 clk = ~clk;

   tvec_op_unit #(.LANES(N), .GRP1(4), .GRP2(2)) u_tvec_op_unit (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_shift(cmd_shift), .vec_a(vec_a), .vec_b(vec_b),
      .vec_out(vec_out), .vec_valid(vec_valid),
      .dot_out(dot_out), .dot_valid(dot_valid)
   );

   function automatic int tv(input logic [1:0] c);
      return (c == 2'b01) ? 1 : (c == 2'b10) ? -1 : 0;
   endfunction

   function automatic logic [1:0] enc(input int v);
      return (v > 0) ? 2'b01 : (v < 0) ? 2'b10 : 2'b00;
   endfunction

   function automatic logic [BW-1:0] model_vec(input int op, input logic [BW-1:0] a,
                                               input logic [BW-1:0] b, input int sh);
      logic [BW-1:0] r = '0;
      for (int i = 0; i < N; i++) begin
         int ta = tv(a[2*i +: 2]);
         int tb = tv(b[2*i +: 2]);
         case (op)
            0: r[2*i +: 2] = enc(ta * tb);
            1: r[2*i +: 2] = enc(ta + tb);
            2: r[2*((i + sh) % N) +: 2] = enc(ta);
            default: r[2*i +: 2] = enc(ta > 0 ? ta : 0);
         endcase
      end
      return r;
   endfunction

   function automatic int model_dot(input logic [BW-1:0] a, input logic [BW-1:0] b);
      int s = 0;
      for (int i = 0; i < N; i++) s += tv(a[2*i +: 2]) * tv(b[2*i +: 2]);
      return s;
   endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] x);
      logic [31:0] y = x;
      y = y ^ (y << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // vector command: result visible at the next falling edge
   task automatic run_vec(input int op, input logic [BW-1:0] a, input logic [BW-1:0] b,
                          input int sh, input string tag);
      logic [BW-1:0] exp = model_vec(op, a, b, sh);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_shift = SW'(sh); vec_a = a; vec_b = b;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(vec_valid === 1'b1 && vec_out === exp, tag, {31'd0, vec_valid, vec_out},
            {32'd1, exp});
   endtask

   // single dot command with latency probe
   task automatic run_dot(input logic [BW-1:0] a, input logic [BW-1:0] b);
      int exp = model_dot(a, b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd4; vec_a = a; vec_b = b;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(dot_valid === 1'b0, "R7 dot_valid early (1)", dot_valid, 0);
      @(negedge clk);
      check(dot_valid === 1'b0, "R7 dot_valid early (2)", dot_valid, 0);
      @(negedge clk);
      check(dot_valid === 1'b1 && int'(dot_out) == exp, "R7 dot value at cycle 3",
            int'(dot_out), exp);
      @(negedge clk);
      check(dot_valid === 1'b0, "R7 dot_valid single pulse", dot_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [BW-1:0] combo_a, combo_b, last_vec, ra, rb;
      logic [BW-1:0] sa [NSTR];
      logic [BW-1:0] sb [NSTR];

      // lane i holds code pair (i[3:2], i[1:0]): all 16 pairs incl. illegal 2'b11
      for (int i = 0; i < N; i++) begin
         combo_a[2*i +: 2] = 2'(i >> 2);
         combo_b[2*i +: 2] = 2'(i);
      end

      repeat (3) @(negedge clk);
      check(vec_out === '0 && vec_valid === 1'b0 && dot_out === '0 && dot_valid === 1'b0,
            "R10 reset state", {vec_valid, dot_valid, vec_out}, 0);
      rst_n = 1'b1;

      // exhaustive pair sweep (R1 illegal code as zero)
      run_vec(0, combo_a, combo_b, 0, "R3 R1 bind all code pairs");
      run_vec(1, combo_a, combo_b, 0, "R4 R1 bundle all code pairs");
      run_vec(3, combo_a, combo_b, 0, "R6 R1 rectify all codes");
      @(negedge clk);
      check(vec_valid === 1'b0, "R8 vec_valid one-cycle pulse", vec_valid, 0);
      run_dot(combo_a, combo_b);
      run_dot({N{2'b01}}, {N{2'b01}});
      run_dot({N{2'b01}}, {N{2'b10}});

      // every rotation amount, illegal lanes included (R5, R2)
      for (int s = 0; s < N; s++) begin
         run_vec(2, combo_a, combo_b, s, "R5 R2 rotate sweep");
      end

      // pseudo-random operands for every vector operation
      for (int k = 0; k < 40; k++) begin
         seed = next_rand(seed); ra = seed;
         seed = next_rand(seed); rb = seed;
         run_vec(0, ra, rb, 0, "R3 bind random");
         run_vec(1, ra, rb, 0, "R4 bundle random");
         run_vec(2, ra, rb, int'(seed[3:0]), "R5 rotate random");
         run_vec(3, ra, rb, 0, "R6 rectify random");
      end
      last_vec = vec_out;

      // back-to-back dot stream
      for (int k = 0; k < NSTR; k++) begin
         seed = next_rand(seed); sa[k] = seed;
         seed = next_rand(seed); sb[k] = seed;
      end
      for (int t = 0; t < NSTR + 4; t++) begin
         @(negedge clk);
         if (t >= 3 && t - 3 < NSTR) begin
            check(dot_valid === 1'b1 && int'(dot_out) == model_dot(sa[t-3], sb[t-3]),
                  "R7 dot stream", int'(dot_out), model_dot(sa[t-3], sb[t-3]));
         end else if (t < 3 || t - 3 >= NSTR) begin
            check(dot_valid === 1'b0, "R7 dot stream idle", dot_valid, 0);
         end
         if (t < NSTR) begin
            cmd_valid = 1'b1; cmd_op = 3'd4; vec_a = sa[t]; vec_b = sb[t];
         end else begin
            cmd_valid = 1'b0;
         end
      end
      check(vec_out === last_vec && vec_valid === 1'b0, "R8 vec_out held across dots",
            vec_out, last_vec);

      // ignored commands (R9)
      for (int op = 5; op < 8; op++) begin
         @(negedge clk);
         cmd_valid = 1'b1; cmd_op = 3'(op); vec_a = combo_a; vec_b = combo_b;
         @(negedge clk);
         cmd_valid = 1'b0;
         check(vec_valid === 1'b0 && vec_out === last_vec, "R9 reserved opcode vector",
               vec_out, last_vec);
         repeat (2) @(negedge clk);
         check(dot_valid === 1'b0, "R9 reserved opcode dot", dot_valid, 0);
      end
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0; vec_a = combo_a; vec_b = combo_b;
      @(negedge clk);
      check(vec_valid === 1'b0 && vec_out === last_vec, "R9 idle bind ignored",
            vec_out, last_vec);
      cmd_op = 3'd4;
      repeat (3) @(negedge clk);
      check(dot_valid === 1'b0, "R9 idle dot ignored", dot_valid, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule